// File: doc/BRIEF.md
# Two-Port Interleaved Cache Data and Tag Array

This block is the storage core of a direct-mapped data cache that can return two 8-byte words in the same clock cycle. Each 64-byte line is spread across eight word-wide banks, one 8-byte slice per bank. Two requesters can therefore read in parallel as long as their words live in different banks. Each requester has its own private copy of the tag and valid state, so both lookups run at once without sharing a tag port.

When both requesters address the same bank, port 0 is served and port 1 sees its ready signal low. Port 1 keeps its request asserted and is served in a later cycle. A fill port writes a whole line into all eight banks and into both tag copies in a single cycle. During that cycle, neither read port is accepted. Read results come out one cycle after acceptance: a response-valid flag, a hit flag, and the data word.

Top module: `dual_bank_cache`

## Requirements
- R1: A 32-bit address is decoded as follows: bits [31:12] are the tag, bits [11:6] are the set index, bits [5:3] select the bank (the 8-byte word within the line), and bits [2:0] are the byte offset.
- R2: After reset, every set is invalid. Any accepted read returns hit 0 and data 0.
- R3: A fill places slice k of the fill line (fill_data bits [64k+63:64k]) into bank k at the index of fill_addr, for all eight banks at once. A later hitting read of bank k returns that slice.
- R4: A fill updates the tag and valid state of both tag copies. After a fill, a read of that line hits on either port.
- R5: A read accepted at a clock edge produces response-valid, hit and data right after the next edge. With no accepted read, response-valid is 0 after the edge.
- R6: When both ports request and the two addresses fall in different banks, both ready outputs are 1 and both reads complete in the same cycle.
- R7: When both ports request the same bank, port 0 is accepted and p1_ready is 0. Port 1 is accepted in the first cycle in which it still requests and has no conflict.
- R8: While fill_en is 1, both ready outputs are 0 and no read is accepted.
- R9: An accepted read whose set is invalid or whose stored tag differs returns valid 1, hit 0 and data 0.
- R10: The array is direct-mapped. A fill of a set with a new tag replaces the old line, and the old tag then misses.
- R11: Byte offset bits [2:0] do not affect the result. Every byte offset within a word returns the same 8-byte word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| p0_req | input | 1 | Port 0 read request |
| p0_addr | input | 32 | Port 0 byte address |
| p0_ready | output | 1 | Port 0 request accepted this cycle |
| p0_valid | output | 1 | Port 0 response present |
| p0_hit | output | 1 | Port 0 response hit |
| p0_data | output | 64 | Port 0 read word (0 on miss) |
| p1_req | input | 1 | Port 1 read request |
| p1_addr | input | 32 | Port 1 byte address |
| p1_ready | output | 1 | Port 1 request accepted this cycle |
| p1_valid | output | 1 | Port 1 response present |
| p1_hit | output | 1 | Port 1 response hit |
| p1_data | output | 64 | Port 1 read word (0 on miss) |
| fill_en | input | 1 | Write a whole line this cycle |
| fill_addr | input | 32 | Address of the line being filled |
| fill_data | input | 512 | Line contents, slice k for bank k |

## Verification
The bench first reads every bank of a filled line with the two ports on mirrored banks, so a swapped bank select or a wrong slice order shows up as wrong data. Same-bank pairs with different byte offsets test the arbitration and the retry of port 1, which separates a true bank conflict from a plain address compare. Reads to an unfilled set, to a set holding another tag, and to neighbouring indices with the same tag expose faults in valid tracking, tag compare and the index field. A second fill of an occupied set shows that the line is replaced in both tag copies.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 64;
    localparam int WORD_BYTES = 8;
    localparam int NUM_BANKS  = LINE_BYTES / WORD_BYTES;
    localparam int NUM_SETS   = 64;
    localparam int NUM_PORTS  = 2;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BYTE_W = $clog2(WORD_BYTES);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int IDX_W  = $clog2(NUM_SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [BANK_W-1:0] bank;
        logic [BYTE_W-1:0] byte_sel;
    } addr_fields_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
    } bank_rd_t;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
    } rsp_state_t;

    function automatic addr_fields_t split_addr(input logic [ADDR_W-1:0] a);
        return addr_fields_t'(a);
    endfunction
endpackage

// File: rtl/dbc_data_bank.sv
module dbc_data_bank
    import dbc_pkg::*;
#(
    parameter int SETS  = NUM_SETS,
    parameter int WIDTH = WORD_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [$clog2(SETS)-1:0] rd_idx,
    input  logic                    wr_en,
    input  logic [$clog2(SETS)-1:0] wr_idx,
    input  logic [WIDTH-1:0]        wr_data,
    output logic [WIDTH-1:0]        rd_data
);
    logic [WIDTH-1:0] mem [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
        if (rd_en) rd_data <= mem[rd_idx];
    end

    AST_NO_READ_DURING_FILL: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !rd_en); // R8
endmodule

// File: rtl/dbc_tag_copy.sv
module dbc_tag_copy
    import dbc_pkg::*;
#(
    parameter int SETS = NUM_SETS,
    parameter int TW   = TAG_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lk_en,
    input  logic [$clog2(SETS)-1:0] lk_idx,
    input  logic [TW-1:0]           lk_tag,
    input  logic                    fill_en,
    input  logic [$clog2(SETS)-1:0] fill_idx,
    input  logic [TW-1:0]           fill_tag,
    output logic                    hit_q
);
    logic [SETS-1:0] valid;
    logic [TW-1:0]   tags [SETS];

    always_ff @(posedge clk) begin
        if (fill_en) tags[fill_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            hit_q <= 1'b0;
        end else begin
            if (fill_en) valid[fill_idx] <= 1'b1;
            hit_q <= lk_en && valid[lk_idx] && (tags[lk_idx] == lk_tag);
        end
    end

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !fill_en |=> $stable(valid)); // R2
    AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid[$past(fill_idx)]); // R4
    AST_NO_HIT_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        !lk_en |=> !hit_q); // R5
endmodule

// File: rtl/dbc_bank_arb.sv
module dbc_bank_arb
    import dbc_pkg::*;
#(
    parameter int BANKS = NUM_BANKS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req0,
    input  logic                     req1,
    input  logic [$clog2(BANKS)-1:0] bank0,
    input  logic [$clog2(BANKS)-1:0] bank1,
    input  logic [IDX_W-1:0]         idx0,
    input  logic [IDX_W-1:0]         idx1,
    input  logic                     fill_en,
    output logic                     rdy0,
    output logic                     rdy1,
    output logic                     gnt0,
    output logic                     gnt1,
    output bank_rd_t                 bank_rd [BANKS]
);
    logic same_bank;

    always_comb begin
        same_bank = (bank0 == bank1);
        rdy0 = !fill_en;
        rdy1 = !fill_en && !(req0 && same_bank);
        gnt0 = req0 && rdy0;
        gnt1 = req1 && rdy1;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_route
        logic sel0, sel1;
        always_comb begin
            sel0 = gnt0 && (bank0 == ($clog2(BANKS))'(b));
            sel1 = gnt1 && (bank1 == ($clog2(BANKS))'(b));
            bank_rd[b].en  = sel0 || sel1;
            bank_rd[b].idx = sel0 ? idx0 : idx1;
        end
    end

    AST_GRANTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        gnt0 && gnt1 |-> bank0 != bank1); // R6
    AST_PORT0_WINS: assert property (@(posedge clk) disable iff (rst)
        req0 && req1 && (bank0 == bank1) && !fill_en |-> gnt0 && !gnt1); // R7
    AST_FILL_STALLS: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !gnt0 && !gnt1); // R8
endmodule

// File: rtl/dual_bank_cache.sv
module dual_bank_cache
    import dbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              p0_req,
    input  logic [ADDR_W-1:0] p0_addr,
    output logic              p0_ready,
    output logic              p0_valid,
    output logic              p0_hit,
    output logic [WORD_W-1:0] p0_data,
    input  logic              p1_req,
    input  logic [ADDR_W-1:0] p1_addr,
    output logic              p1_ready,
    output logic              p1_valid,
    output logic              p1_hit,
    output logic [WORD_W-1:0] p1_data,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_data
);
    addr_fields_t a0, a1, af;
    logic         gnt0, gnt1;
    bank_rd_t     bank_rd [NUM_BANKS];
    logic [WORD_W-1:0] bank_q [NUM_BANKS];
    logic [NUM_PORTS-1:0] gnt, hit;
    addr_fields_t pa [NUM_PORTS];
    rsp_state_t   rsp [NUM_PORTS];
    logic [WORD_W-1:0] pdata [NUM_PORTS];
    logic unused_bits;

    always_comb begin
        a0 = split_addr(p0_addr);
        a1 = split_addr(p1_addr);
        af = split_addr(fill_addr);
        pa[0] = a0;
        pa[1] = a1;
        gnt = {gnt1, gnt0};
    end
    assign unused_bits = ^{a0.byte_sel, a1.byte_sel, af.bank, af.byte_sel};

    dbc_bank_arb #(.BANKS(NUM_BANKS)) u_arb (
        .clk(clk), .rst(rst),
        .req0(p0_req), .req1(p1_req),
        .bank0(a0.bank), .bank1(a1.bank),
        .idx0(a0.idx), .idx1(a1.idx),
        .fill_en(fill_en),
        .rdy0(p0_ready), .rdy1(p1_ready),
        .gnt0(gnt0), .gnt1(gnt1),
        .bank_rd(bank_rd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dbc_data_bank #(.SETS(NUM_SETS), .WIDTH(WORD_W)) u_bank (
            .clk(clk), .rst(rst),
            .rd_en(bank_rd[b].en), .rd_idx(bank_rd[b].idx),
            .wr_en(fill_en), .wr_idx(af.idx),
            .wr_data(fill_data[b*WORD_W +: WORD_W]),
            .rd_data(bank_q[b])
        );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dbc_tag_copy #(.SETS(NUM_SETS), .TW(TAG_W)) u_tags (
            .clk(clk), .rst(rst),
            .lk_en(gnt[p]), .lk_idx(pa[p].idx), .lk_tag(pa[p].tag),
            .fill_en(fill_en), .fill_idx(af.idx), .fill_tag(af.tag),
            .hit_q(hit[p])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                rsp[p] <= '0;
            end else begin
                rsp[p].vld  <= gnt[p];
                rsp[p].bank <= pa[p].bank;
            end
        end

        always_comb pdata[p] = hit[p] ? bank_q[rsp[p].bank] : '0;
    end

    always_comb begin
        p0_valid = rsp[0].vld;
        p1_valid = rsp[1].vld;
        p0_hit   = hit[0];
        p1_hit   = hit[1];
        p0_data  = pdata[0];
        p1_data  = pdata[1];
    end

    AST_P0_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        p0_req && p0_ready |=> p0_valid); // R5
    AST_P1_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        p1_req && p1_ready |=> p1_valid); // R5
    AST_P0_HIT_IN_RSP: assert property (@(posedge clk) disable iff (rst)
        p0_hit |-> p0_valid); // R9
    AST_P1_HIT_IN_RSP: assert property (@(posedge clk) disable iff (rst)
        p1_hit |-> p1_valid); // R9
    AST_FILL_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> !p0_valid && !p1_valid); // R8
endmodule

// File: tb/dual_bank_cache_test.sv
module dual_bank_cache_test;
    import dbc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic p0_req = 1'b0, p1_req = 1'b0, fill_en = 1'b0;
    logic [ADDR_W-1:0] p0_addr = '0, p1_addr = '0, fill_addr = '0;
    logic [LINE_W-1:0] fill_data = '0;
    logic p0_ready, p0_valid, p0_hit, p1_ready, p1_valid, p1_hit;
    logic [WORD_W-1:0] p0_data, p1_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic r_rdy0, r_rdy1, r_v0, r_v1, r_h0, r_h1;
    logic [WORD_W-1:0] r_d0, r_d1;

    always #5 clk = ~clk;

    dual_bank_cache uut (
        .clk(clk), .rst(rst),
        .p0_req(p0_req), .p0_addr(p0_addr), .p0_ready(p0_ready),
        .p0_valid(p0_valid), .p0_hit(p0_hit), .p0_data(p0_data),
        .p1_req(p1_req), .p1_addr(p1_addr), .p1_ready(p1_ready),
        .p1_valid(p1_valid), .p1_hit(p1_hit), .p1_data(p1_data),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [TAG_W-1:0] t,
        input int idx, input int bank, input int bsel);
        return {t, IDX_W'(idx), BANK_W'(bank), BYTE_W'(bsel)};
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input int line_id, input int k);
        return {32'hA5A50000 + 32'(line_id), 32'(k) * 32'h01010101};
    endfunction

    function automatic logic [LINE_W-1:0] line_of(input int line_id);
        logic [LINE_W-1:0] l;
        for (int k = 0; k < NUM_BANKS; k++) l[k*WORD_W +: WORD_W] = word_of(line_id, k);
        return l;
    endfunction

    task automatic chk(input string req, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle2(input logic e0, input logic [ADDR_W-1:0] a0,
                          input logic e1, input logic [ADDR_W-1:0] a1);
        @(negedge clk);
        p0_req = e0; p0_addr = a0; p1_req = e1; p1_addr = a1; fill_en = 1'b0;
        #1;
        r_rdy0 = p0_ready; r_rdy1 = p1_ready;
        @(posedge clk);
        #1;
        r_v0 = p0_valid; r_h0 = p0_hit; r_d0 = p0_data;
        r_v1 = p1_valid; r_h1 = p1_hit; r_d1 = p1_data;
    endtask

    task automatic idle();
        @(negedge clk);
        p0_req = 1'b0; p1_req = 1'b0; fill_en = 1'b0;
    endtask

    task automatic do_fill(input logic [ADDR_W-1:0] a, input int line_id);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = a; fill_data = line_of(line_id);
        p0_req = 1'b1; p0_addr = a; p1_req = 1'b1; p1_addr = a | 32'h8;
        #1;
        chk("R8 p0_ready during fill", 64'(p0_ready), 64'd0);
        chk("R8 p1_ready during fill", 64'(p1_ready), 64'd0);
        @(posedge clk);
        #1;
        chk("R8 no p0 response after fill", 64'(p0_valid), 64'd0);
        chk("R8 no p1 response after fill", 64'(p1_valid), 64'd0);
        idle();
    endtask

    localparam logic [TAG_W-1:0] TAG_A = 20'h12345;
    localparam logic [TAG_W-1:0] TAG_B = 20'h0BEEF;
    localparam logic [TAG_W-1:0] TAG_C = 20'hFFFFF;

    task automatic t_reset();
        @(negedge clk);
        chk("R2 reset p0_valid", 64'(p0_valid), 64'd0);
        chk("R2 reset p1_valid", 64'(p1_valid), 64'd0);
        cycle2(1'b1, mk_addr(TAG_A, 5, 0, 0), 1'b1, mk_addr(TAG_A, 5, 1, 0));
        chk("R2 cold p0 valid", 64'(r_v0), 64'd1);
        chk("R2 cold p0 hit", 64'(r_h0), 64'd0);
        chk("R2 cold p0 data", r_d0, 64'd0);
        chk("R2 cold p1 hit", 64'(r_h1), 64'd0);
        idle();
    endtask

    task automatic t_parallel();
        do_fill(mk_addr(TAG_A, 5, 0, 0), 1);
        for (int k = 0; k < NUM_BANKS; k++) begin
            cycle2(1'b1, mk_addr(TAG_A, 5, k, k), 1'b1, mk_addr(TAG_A, 5, 7 - k, 7 - k));
            chk("R6 p0 ready", 64'(r_rdy0), 64'd1);
            chk("R6 p1 ready", 64'(r_rdy1), 64'd1);
            chk("R5 p0 valid", 64'(r_v0), 64'd1);
            chk("R4 p0 hit", 64'(r_h0), 64'd1);
            chk("R4 p1 hit", 64'(r_h1), 64'd1);
            chk("R3 p0 slice", r_d0, word_of(1, k));
            chk("R3 R11 p1 slice", r_d1, word_of(1, 7 - k));
        end
        idle();
        @(posedge clk); #1;
        chk("R5 idle clears p0_valid", 64'(p0_valid), 64'd0);
    endtask

    task automatic t_conflict();
        cycle2(1'b1, mk_addr(TAG_A, 5, 2, 1), 1'b1, mk_addr(TAG_A, 5, 2, 6));
        chk("R7 p0 ready on conflict", 64'(r_rdy0), 64'd1);
        chk("R7 p1 stalled on conflict", 64'(r_rdy1), 64'd0);
        chk("R7 p0 served", r_d0, word_of(1, 2));
        chk("R7 p1 no response", 64'(r_v1), 64'd0);
        cycle2(1'b0, mk_addr(TAG_A, 5, 2, 1), 1'b1, mk_addr(TAG_A, 5, 2, 6));
        chk("R7 p1 ready on retry", 64'(r_rdy1), 64'd1);
        chk("R7 p1 retry valid", 64'(r_v1), 64'd1);
        chk("R11 p1 retry data", r_d1, word_of(1, 2));
        chk("R5 p0 dropped no response", 64'(r_v0), 64'd0);
        idle();
    endtask

    task automatic t_miss();
        cycle2(1'b1, mk_addr(TAG_B, 5, 3, 0), 1'b1, mk_addr(TAG_A, 6, 4, 0));
        chk("R9 tag mismatch valid", 64'(r_v0), 64'd1);
        chk("R9 tag mismatch hit", 64'(r_h0), 64'd0);
        chk("R9 tag mismatch data", r_d0, 64'd0);
        chk("R9 empty set hit", 64'(r_h1), 64'd0);
        chk("R9 empty set data", r_d1, 64'd0);
        idle();
    endtask

    task automatic t_replace();
        do_fill(mk_addr(TAG_B, 5, 0, 0), 2);
        cycle2(1'b1, mk_addr(TAG_B, 5, 6, 0), 1'b1, mk_addr(TAG_A, 5, 1, 0));
        chk("R10 new tag hits", 64'(r_h0), 64'd1);
        chk("R10 new data", r_d0, word_of(2, 6));
        chk("R10 old tag misses", 64'(r_h1), 64'd0);
        cycle2(1'b1, mk_addr(TAG_A, 5, 6, 0), 1'b1, mk_addr(TAG_B, 5, 1, 0));
        chk("R10 old tag misses p0", 64'(r_h0), 64'd0);
        chk("R4 new tag copy 1", r_d1, word_of(2, 1));
        idle();
    endtask

    task automatic t_fields();
        do_fill(mk_addr(TAG_C, 63, 0, 0), 3);
        cycle2(1'b1, mk_addr(TAG_C, 63, 7, 7), 1'b1, mk_addr(TAG_C, 62, 0, 0));
        chk("R1 top index hit", 64'(r_h0), 64'd1);
        chk("R1 top index data", r_d0, word_of(3, 7));
        chk("R1 neighbour index misses", 64'(r_h1), 64'd0);
        cycle2(1'b1, mk_addr(TAG_C ^ 20'h80000, 63, 0, 0), 1'b1, mk_addr(TAG_C, 63, 4, 3));
        chk("R1 tag msb differs misses", 64'(r_h0), 64'd0);
        chk("R1 bank field picks slice", r_d1, word_of(3, 4));
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_parallel();
        t_conflict();
        t_miss();
        t_replace();
        t_fields();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule